// File: doc/BRIEF.md
# Shared Program and Data Memory

A word-organised RAM serves two masters at once: a processor's instruction fetch and its load/store unit. The fetch side is read-only. It takes a byte address and returns the whole 32-bit word that contains it. The data side takes a byte address, a write enable, 32-bit write data and a two-bit access-size code. With that code it reads or writes a byte, a halfword or a word.

Narrow accesses always use the least significant lanes of the addressed word, whatever the low address bits are. Narrow reads come back zero-extended. The size code 3 reads the whole word and never writes. Writes are committed on the rising clock edge. Both read paths are combinational from their addresses. A synchronous, active-high reset suppresses every write while it is held.

The depth in words is a power-of-two parameter. Addresses beyond it alias back onto the array.

Top module: `umem_unified`

## Requirements
- R1: The word index of either port is the byte address shifted right by two; address bits 1:0 do not affect which word is selected (address 0x1000 selects word 1024).
- R2: The fetch output presents, in the same cycle, the full 32-bit word at the fetch address.
- R3: Size code values are 0 = byte (8 bits), 1 = halfword (16 bits), 2 = word (32 bits), 3 = read whole word, write nothing.
- R4: A byte store (write enable 1, code 0) replaces bits 7:0 of the addressed word and keeps bits 31:8.
- R5: A halfword store (code 1) replaces bits 15:0 and keeps bits 31:16.
- R6: A word store (code 2) replaces all 32 bits with the write data.
- R7: A store with code 3 leaves the addressed word unchanged even with the write enable at 1.
- R8: A byte load returns bits 7:0 of the word, and a halfword load returns bits 15:0; all upper bits read as zero.
- R9: A load with code 2 or 3 returns the full 32-bit word.
- R10: While reset is 1, no word is written, whatever the write enable.
- R11: A write becomes visible on both read ports in the cycle after its clock edge. A read of the same word in the cycle of the write shows the previous contents.
- R12: With the write enable at 0, no word changes, whatever the write data and size code.
- R13: Word indices wrap modulo the depth: with the default of 2048 words, byte addresses 0x2010 and 0xFFFFE010 alias address 0x0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes |
| ifetch_addr | input | ADDR_W | Byte address of the instruction fetch |
| ifetch_data | output | 32 | Full word at the fetch address |
| dmem_addr | input | ADDR_W | Byte address of the load/store access |
| dmem_wdata | input | 32 | Store data; the low lanes are used for narrow stores |
| dmem_we | input | 1 | Store enable |
| dmem_width | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 read-only word) |
| dmem_rdata | output | 32 | Zero-extended load result |

## Verification
The situation hardest to create from the ports is a read of a word in the same cycle that the word is being rewritten. The read must show the old value before the edge and the new value after it. The bench drives each store with its address held, samples the data output and the fetch output one nanosecond after the inputs settle, and only then lets the edge commit. One directed step points the fetch port at the word the data port is overwriting. Store masking is shown indirectly: the bench first fills a word with a distinctive full pattern, so that every lane that must survive a narrow or blocked store holds a known, non-zero value.

// File: rtl/umem_pkg.sv
package umem_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_HOLD = 2'd3
    } acc_width_e;

    typedef struct packed {
        logic              en;
        logic [WORD_W-1:0] word;
    } store_op_t;

    // Merge store data into the low lanes of the existing word.
    function automatic logic [WORD_W-1:0] merge_store(
        input logic [WORD_W-1:0] old_word,
        input logic [WORD_W-1:0] wdata,
        input acc_width_e        width
    );
        logic [WORD_W-1:0] res;
        res = old_word;
        case (width)
            ACC_BYTE: res[7:0]  = wdata[7:0];
            ACC_HALF: res[15:0] = wdata[15:0];
            ACC_WORD: res       = wdata;
            default:  res       = old_word;
        endcase
        return res;
    endfunction

    // Zero-extend the low lanes selected by the size code.
    function automatic logic [WORD_W-1:0] shape_load(
        input logic [WORD_W-1:0] word,
        input acc_width_e        width
    );
        logic [WORD_W-1:0] res;
        case (width)
            ACC_BYTE: res = {{(WORD_W-8){1'b0}},  word[7:0]};
            ACC_HALF: res = {{(WORD_W-16){1'b0}}, word[15:0]};
            default:  res = word;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/umem_store_lane.sv
module umem_store_lane
    import umem_pkg::*;
(
    input  logic              we,
    input  acc_width_e        width,
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] wdata,
    output store_op_t         op
);
    always_comb begin
        op.en   = we && (width != ACC_HOLD);
        op.word = merge_store(old_word, wdata, width);
    end
endmodule

// File: rtl/umem_load_lane.sv
module umem_load_lane
    import umem_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  acc_width_e        width,
    output logic [WORD_W-1:0] data
);
    always_comb data = shape_load(word, width);
endmodule

// File: rtl/umem_array.sv
module umem_array
    import umem_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  store_op_t         wr_op,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [IDX_W-1:0]  rda_idx,
    output logic [WORD_W-1:0] rda_word,
    input  logic [IDX_W-1:0]  rdb_idx,
    output logic [WORD_W-1:0] rdb_word
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst && wr_op.en) begin
            mem_q[wr_idx] <= wr_op.word;
        end
    end

    assign rda_word = mem_q[rda_idx];
    assign rdb_word = mem_q[rdb_idx];

    // R11: a committed write holds the stored word in the following cycle
    a_r11_write_visible: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_op.en) |=> (mem_q[$past(wr_idx)] == $past(wr_op.word)));
endmodule

// File: rtl/umem_unified.sv
module umem_unified
    import umem_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ifetch_addr,
    output logic [WORD_W-1:0] ifetch_data,
    input  logic [ADDR_W-1:0] dmem_addr,
    input  logic [WORD_W-1:0] dmem_wdata,
    input  logic              dmem_we,
    input  logic [1:0]        dmem_width,
    output logic [WORD_W-1:0] dmem_rdata
);
    logic [IDX_W-1:0]  d_idx;
    logic [IDX_W-1:0]  i_idx;
    logic [WORD_W-1:0] d_word;
    acc_width_e        acc;
    store_op_t         st_op;
    logic              unused_addr_bits;

    assign acc   = acc_width_e'(dmem_width);
    assign d_idx = dmem_addr[IDX_W+1:2];
    assign i_idx = ifetch_addr[IDX_W+1:2];

    generate
        if (ADDR_W > IDX_W + 2) begin : g_hi
            assign unused_addr_bits = ^{dmem_addr[1:0], ifetch_addr[1:0],
                                        dmem_addr[ADDR_W-1:IDX_W+2],
                                        ifetch_addr[ADDR_W-1:IDX_W+2]};
        end else begin : g_lo
            assign unused_addr_bits = ^{dmem_addr[1:0], ifetch_addr[1:0]};
        end
    endgenerate

    umem_store_lane i_store (
        .we       (dmem_we),
        .width    (acc),
        .old_word (d_word),
        .wdata    (dmem_wdata),
        .op       (st_op)
    );

    umem_array #(.DEPTH(DEPTH)) i_array (
        .clk      (clk),
        .rst      (rst),
        .wr_op    (st_op),
        .wr_idx   (d_idx),
        .rda_idx  (d_idx),
        .rda_word (d_word),
        .rdb_idx  (i_idx),
        .rdb_word (ifetch_data)
    );

    umem_load_lane i_load (
        .word  (d_word),
        .width (acc),
        .data  (dmem_rdata)
    );

    // R4: byte store keeps bits 31:8
    a_r4_byte_keep: assert property (@(posedge clk) disable iff (rst)
        (!rst && dmem_we && dmem_width == 2'd0) |=>
        (i_array.mem_q[$past(d_idx)][31:8] == $past(d_word[31:8])));

    // R5: halfword store keeps bits 31:16
    a_r5_half_keep: assert property (@(posedge clk) disable iff (rst)
        (!rst && dmem_we && dmem_width == 2'd1) |=>
        (i_array.mem_q[$past(d_idx)][31:16] == $past(d_word[31:16])));

    // R6: word store takes the write data whole
    a_r6_word_store: assert property (@(posedge clk) disable iff (rst)
        (!rst && dmem_we && dmem_width == 2'd2) |=>
        (i_array.mem_q[$past(d_idx)] == $past(dmem_wdata)));

    // R7: size code 3 never changes the word
    a_r7_hold_store: assert property (@(posedge clk) disable iff (rst)
        (!rst && dmem_width == 2'd3) |=>
        (i_array.mem_q[$past(d_idx)] == $past(d_word)));

    // R8: narrow loads are zero-extended
    a_r8_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (dmem_width == 2'd0) |-> (dmem_rdata[31:8] == 24'd0));
endmodule

// File: tb/test_umem_unified.sv
`timescale 1ns/1ps
module test_umem_unified;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] ifetch_addr;
    logic [31:0] ifetch_data;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic [1:0]  dmem_width;
    logic [31:0] dmem_rdata;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    umem_unified i_umem_unified (
        .clk         (clk),
        .rst         (rst),
        .ifetch_addr (ifetch_addr),
        .ifetch_data (ifetch_data),
        .dmem_addr   (dmem_addr),
        .dmem_wdata  (dmem_wdata),
        .dmem_we     (dmem_we),
        .dmem_width  (dmem_width),
        .dmem_rdata  (dmem_rdata)
    );

    // {we, width, addr, wdata, check, expected data-port read before the edge}
    localparam logic [99:0] VECS [0:15] = '{
        {1'b1, 2'd2, 32'h0000_1000, 32'h1122_3344, 1'b0, 32'h0},            // fill word 1024
        {1'b0, 2'd2, 32'h0000_1000, 32'h0,         1'b1, 32'h1122_3344},    // R6 R1
        {1'b1, 2'd0, 32'h0000_1000, 32'hDEAD_BEEF, 1'b1, 32'h0000_0044},    // R8 R11 old byte
        {1'b0, 2'd2, 32'h0000_1000, 32'h0,         1'b1, 32'h1122_33EF},    // R4
        {1'b1, 2'd1, 32'h0000_1001, 32'hCAFE_F00D, 1'b1, 32'h0000_33EF},    // R8 R1 half
        {1'b0, 2'd3, 32'h0000_1003, 32'h0,         1'b1, 32'h1122_F00D},    // R5 R9 R1
        {1'b1, 2'd3, 32'h0000_1000, 32'hFFFF_FFFF, 1'b1, 32'h1122_F00D},    // R9 R3
        {1'b0, 2'd2, 32'h0000_1000, 32'h0,         1'b1, 32'h1122_F00D},    // R7
        {1'b0, 2'd1, 32'h0000_1002, 32'h0,         1'b1, 32'h0000_F00D},    // R8
        {1'b1, 2'd2, 32'h0000_1004, 32'hA5A5_A5A5, 1'b0, 32'h0},            // fill word 1025
        {1'b0, 2'd0, 32'h0000_1004, 32'h1234_5678, 1'b1, 32'h0000_00A5},    // R8
        {1'b0, 2'd2, 32'h0000_1004, 32'h0,         1'b1, 32'hA5A5_A5A5},    // R12
        {1'b0, 2'd2, 32'h0000_1000, 32'h0,         1'b1, 32'h1122_F00D},    // R12 neighbour
        {1'b1, 2'd2, 32'h0000_0010, 32'h0BAD_C0DE, 1'b0, 32'h0},            // fill word 4
        {1'b0, 2'd2, 32'h0000_2010, 32'h0,         1'b1, 32'h0BAD_C0DE},    // R13
        {1'b0, 2'd2, 32'hFFFF_E010, 32'h0,         1'b1, 32'h0BAD_C0DE}     // R13
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic [1:0] w,
                         input logic [31:0] a, input logic [31:0] d);
        dmem_we    = we;
        dmem_width = w;
        dmem_addr  = a;
        dmem_wdata = d;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst         = 1'b1;
        ifetch_addr = 32'h0;
        drive(1'b0, 2'd2, 32'h0, 32'h0);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            drive(VECS[k][99], VECS[k][98:97], VECS[k][96:65], VECS[k][64:33]);
            #1;
            if (VECS[k][32]) check($sformatf("vector %0d (R1..R13 table)", k),
                                   dmem_rdata, VECS[k][31:0]);
        end

        // R2: fetch port full words, advancing by four
        @(negedge clk);
        drive(1'b0, 2'd2, 32'h0, 32'h0);
        ifetch_addr = 32'h0000_1000;
        #1 check("R2 fetch word 1024", ifetch_data, 32'h1122_F00D);
        ifetch_addr = 32'h0000_1004;
        #1 check("R2 fetch word 1025", ifetch_data, 32'hA5A5_A5A5);
        ifetch_addr = 32'h0000_2012;
        #1 check("R13 R1 fetch wrap", ifetch_data, 32'h0BAD_C0DE);

        // R11: fetch reads the word being overwritten in the same cycle
        @(negedge clk);
        ifetch_addr = 32'h0000_1000;
        drive(1'b1, 2'd2, 32'h0000_1000, 32'h5555_5555);
        #1 check("R11 fetch old before edge", ifetch_data, 32'h1122_F00D);
        @(negedge clk);
        drive(1'b0, 2'd2, 32'h0000_1000, 32'h0);
        #1 check("R11 fetch new after edge", ifetch_data, 32'h5555_5555);
        check("R11 data port new after edge", dmem_rdata, 32'h5555_5555);

        // R10: writes blocked while reset is held
        @(negedge clk);
        rst = 1'b1;
        drive(1'b1, 2'd2, 32'h0000_1004, 32'h0000_0000);
        repeat (2) @(negedge clk);
        drive(1'b1, 2'd0, 32'h0000_1000, 32'h0000_0099);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 2'd2, 32'h0000_1004, 32'h0);
        #1 check("R10 word store under reset", dmem_rdata, 32'hA5A5_A5A5);
        dmem_addr = 32'h0000_1000;
        #1 check("R10 byte store under reset", dmem_rdata, 32'h5555_5555);

        // R3 R9: code 3 reads a full word
        dmem_width = 2'd3;
        #1 check("R3 R9 code 3 full read", dmem_rdata, 32'h5555_5555);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule